// File: doc/BRIEF.md
# Three-Stage Interlocked Pipeline Core

This block is a small in-order processor core built as three stages: fetch, execute and writeback. It runs 16-bit instructions from an external synchronous instruction ROM and writes results into four 8-bit registers, or to an external data memory through a valid/ready write port. Without hazards it completes one instruction per clock, and each instruction takes three cycles from fetch to retirement.

The core does no forwarding and no prediction. An instruction in execute that reads a register still waiting in writeback stalls for one cycle, and a bubble enters writeback. A branch-if-zero or halt in execute blocks fetch for that cycle. A halt stops all further fetch, lets older work drain, and then raises `done`. The register file and a retired-instruction counter are exposed for debug.

Back-pressure rules for the store port: `dmem_wvalid` is high while a store sits in writeback. `dmem_waddr` and `dmem_wdata` stay constant until a cycle in which `dmem_wready` is also high, and that cycle completes the write. While a store waits, the whole core is frozen: the program counter, the execute instruction, writeback and the counter all hold. `dmem_wready` may change freely when `dmem_wvalid` is low.

Top module: `tp_core`

## Requirements
- R1: An instruction is {opcode[15:12], rd[11:10], rs[9:8], imm[7:0]}. The opcodes are 1 = load imm into rd, 2 = copy rs to rd, 3 = add imm to rd (modulo 256), and 4 = write rs to data address imm. `dbg_regs[8*i+7:8*i]` shows register i.
- R2: An instruction requested on `imem_addr` in cycle n with `imem_en` high updates its register on the edge that ends cycle n+2. Independent instructions are fetched on consecutive cycles, so the core completes one per clock.
- R3: Suppose the instruction in execute reads a register that the instruction in writeback is writing. The read register is rs for opcodes 2, 4 and 5, and rd for opcode 3. For one cycle, `imem_en` is then low, the fetch address holds, and no store or retirement follows from the bubble.
- R4: Opcode 5 (branch if rs is zero, target imm) is resolved in execute. In that cycle `imem_en` is low. The next fetch address is imm if rs was zero, otherwise the address after the branch.
- R5: Opcode 6 (halt) stops fetch from the cycle it reaches execute. `done` rises once the halt has left writeback and then stays high until reset.
- R6: A store in writeback holds `dmem_wvalid` with a stable address and data until `dmem_wready`. The store is written exactly once, and nothing else in the core advances in the meantime.
- R7: While `rst` is high at a clock edge, the core clears the fetch address to 0, all registers, the retired count and `done`.
- R8: `dbg_retired` goes up by one for each instruction that leaves writeback, counting branches, halts and no-ops, and never goes up by more than one per cycle.
- R9: Opcodes 0 and 7 to 15 act as no-ops: they change no register and issue no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_en | output | 1 | Instruction ROM read enable; ROM output holds when low |
| imem_addr | output | 8 | Instruction fetch address |
| imem_rdata | input | 16 | ROM data, registered one cycle after an enabled read |
| dmem_wvalid | output | 1 | Store request valid |
| dmem_wready | input | 1 | Data memory accepts the store |
| dmem_waddr | output | 8 | Store address |
| dmem_wdata | output | 8 | Store data |
| dbg_regs | output | 32 | Register file, register i at bits 8*i+7:8*i |
| dbg_retired | output | 16 | Retired instruction count |
| done | output | 1 | Halt has retired and the pipeline is empty |

## Verification
Some rules are checked by assertions on every cycle. These are: a pending store stays stable until it is accepted, an interlock freezes the fetch address and produces no store, a branch or halt in execute never coexists with a fetch, `done` is sticky, the counter steps by zero or one, and reset clears the core. Only the bench's programs can show the results and the timing. The bench compares a behavioural model cycle by cycle and checks exact completion edges. That covers the data values, the one-cycle penalty per dependence, taken versus fall-through redirection, no-op handling and single delivery of stores under an irregular ready pattern.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int DATA_W  = 8;
  localparam int NREGS   = 4;
  localparam int RSEL_W  = $clog2(NREGS);
  localparam int ADDR_W  = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'd0,
    OP_LDI  = 4'd1,
    OP_MOV  = 4'd2,
    OP_ADDI = 4'd3,
    OP_STR  = 4'd4,
    OP_BZ   = 4'd5,
    OP_HALT = 4'd6
  } op_e;

  typedef struct packed {
    logic              valid;
    logic              wen;
    logic              store;
    logic [RSEL_W-1:0] rd;
    logic [DATA_W-1:0] val;
    logic [ADDR_W-1:0] addr;
  } wb_t;
endpackage

// File: rtl/tp_fetch.sv
module tp_fetch
  import tp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              fetch_go,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              halt_set,
  output logic [ADDR_W-1:0] pc,
  output logic              ex_valid,
  output logic              halted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ex_valid <= 1'b0;
      halted   <= 1'b0;
    end else if (!stall) begin
      ex_valid <= fetch_go;
      if (redirect)      pc <= redirect_pc;
      else if (fetch_go) pc <= pc + ADDR_W'(1);
      if (halt_set)      halted <= 1'b1;
    end
  end
endmodule

// File: rtl/tp_regfile.sv
module tp_regfile
  import tp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [RSEL_W-1:0]       waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [RSEL_W-1:0]       raddr,
  output logic [DATA_W-1:0]       rdata,
  output logic [NREGS*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              regs[i] <= '0;
      else if (we && waddr == RSEL_W'(i))   regs[i] <= wdata;
    end
    assign flat[i*DATA_W +: DATA_W] = regs[i];
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/tp_exec.sv
module tp_exec
  import tp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [INSTR_W-1:0] instr,
  input  logic               ex_valid,
  input  logic [DATA_W-1:0]  opnd,
  output logic [RSEL_W-1:0]  src_sel,
  output logic               hazard,
  output logic               fetch_block,
  output logic               redirect,
  output logic [ADDR_W-1:0]  redirect_pc,
  output logic               halt_set,
  output wb_t                wb
);
  logic [OPC_W-1:0]  opc;
  logic [RSEL_W-1:0] rd, rs;
  logic [DATA_W-1:0] imm;
  logic              reads;
  wb_t               wb_next;

  assign opc = instr[INSTR_W-1 -: OPC_W];
  assign rd  = instr[INSTR_W-OPC_W-1 -: RSEL_W];
  assign rs  = instr[INSTR_W-OPC_W-RSEL_W-1 -: RSEL_W];
  assign imm = instr[DATA_W-1:0];

  assign src_sel = (opc == OP_ADDI) ? rd : rs;
  assign reads   = (opc == OP_MOV) || (opc == OP_ADDI) ||
                   (opc == OP_STR) || (opc == OP_BZ);
  assign hazard  = ex_valid && reads && wb.valid && wb.wen && (wb.rd == src_sel);

  assign fetch_block = ex_valid && ((opc == OP_BZ) || (opc == OP_HALT));
  assign redirect    = ex_valid && !hazard && (opc == OP_BZ) && (opnd == '0);
  assign redirect_pc = ADDR_W'(imm);
  assign halt_set    = ex_valid && (opc == OP_HALT);

  always_comb begin
    wb_next       = '0;
    wb_next.valid = ex_valid && !hazard;
    wb_next.rd    = rd;
    wb_next.addr  = ADDR_W'(imm);
    unique case (opc)
      OP_LDI:  begin wb_next.wen = 1'b1; wb_next.val = imm;        end
      OP_MOV:  begin wb_next.wen = 1'b1; wb_next.val = opnd;       end
      OP_ADDI: begin wb_next.wen = 1'b1; wb_next.val = opnd + imm; end
      OP_STR:  begin wb_next.store = 1'b1; wb_next.val = opnd;     end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        wb <= '0;
    else if (!hold) wb <= wb_next;
  end
endmodule

// File: rtl/tp_core.sv
module tp_core
  import tp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    imem_en,
  output logic [ADDR_W-1:0]       imem_addr,
  input  logic [INSTR_W-1:0]      imem_rdata,
  output logic                    dmem_wvalid,
  input  logic                    dmem_wready,
  output logic [ADDR_W-1:0]       dmem_waddr,
  output logic [DATA_W-1:0]       dmem_wdata,
  output logic [NREGS*DATA_W-1:0] dbg_regs,
  output logic [CNT_W-1:0]        dbg_retired,
  output logic                    done
);
  logic [ADDR_W-1:0] pc, redirect_pc;
  logic              ex_valid, halted, hazard, fetch_block, redirect, halt_set;
  logic              dstall, stall, fetch_go;
  logic [RSEL_W-1:0] src_sel;
  logic [DATA_W-1:0] opnd;
  wb_t               wb;

  assign dstall   = wb.valid && wb.store && !dmem_wready;
  assign stall    = hazard || dstall;
  assign fetch_go = !halted && !fetch_block && !stall;

  tp_fetch u_fetch (
    .clk, .rst, .stall, .fetch_go, .redirect, .redirect_pc, .halt_set,
    .pc, .ex_valid, .halted
  );

  tp_exec u_exec (
    .clk, .rst, .hold(dstall), .instr(imem_rdata), .ex_valid, .opnd,
    .src_sel, .hazard, .fetch_block, .redirect, .redirect_pc, .halt_set, .wb
  );

  tp_regfile u_rf (
    .clk, .rst, .we(wb.valid && wb.wen), .waddr(wb.rd), .wdata(wb.val),
    .raddr(src_sel), .rdata(opnd), .flat(dbg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst)                    dbg_retired <= '0;
    else if (wb.valid && !dstall) dbg_retired <= dbg_retired + CNT_W'(1);
  end

  assign imem_en     = fetch_go;
  assign imem_addr   = pc;
  assign dmem_wvalid = wb.valid && wb.store;
  assign dmem_waddr  = wb.addr;
  assign dmem_wdata  = wb.val;
  assign done        = halted && !wb.valid;
endmodule

// File: rtl/tp_core_chk.sv
module tp_core_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          imem_en,
  input logic          dmem_wvalid,
  input logic          dmem_wready,
  input logic [AW-1:0] dmem_waddr,
  input logic [DW-1:0] dmem_wdata,
  input logic [CW-1:0] dbg_retired,
  input logic          done,
  input logic          hazard,
  input logic          fetch_block,
  input logic [AW-1:0] pc
);
  // R6
  store_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_wvalid && !dmem_wready |=> dmem_wvalid && $stable(dmem_waddr) && $stable(dmem_wdata));
  // R3
  interlock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |=> $stable(pc) && !dmem_wvalid);
  // R3
  interlock_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |-> !imem_en);
  // R4
  branch_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_block |-> !imem_en);
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !imem_en);
  // R8
  retire_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dbg_retired == $past(dbg_retired)) || (dbg_retired == $past(dbg_retired) + CW'(1)));
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> dbg_retired == '0 && !done && pc == '0);
endmodule

bind tp_core tp_core_chk #(.AW(tp_pkg::ADDR_W), .DW(tp_pkg::DATA_W), .CW(CNT_W)) u_chk (
  .clk, .rst, .imem_en, .dmem_wvalid, .dmem_wready, .dmem_waddr, .dmem_wdata,
  .dbg_retired, .done, .hazard, .fetch_block, .pc
);

// File: tb/sim_tp_core.sv
module sim_tp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_en, dmem_wvalid, done;
  logic        dmem_wready = 1'b1;
  logic [7:0]  imem_addr, dmem_waddr, dmem_wdata;
  logic [15:0] imem_rdata = '0;
  logic [31:0] dbg_regs;
  logic [15:0] dbg_retired;

  int checks = 0, failures = 0, edges = 0;
  bit bp_mode = 0;

  logic [15:0] rom [256];
  logic [7:0]  dmem [256];
  int          n_writes = 0;

  // reference model state
  int          m_pc, m_cnt;
  bit          m_exv, m_halt, m_wbv, m_wen, m_st;
  logic [15:0] m_ex;
  int          m_rd, m_val, m_addr;
  int          m_regs [4];

  always #10 clk = ~clk;

  tp_core u0 (.clk, .rst, .imem_en, .imem_addr, .imem_rdata, .dmem_wvalid,
              .dmem_wready, .dmem_waddr, .dmem_wdata, .dbg_regs, .dbg_retired, .done);

  always @(posedge clk) if (imem_en) imem_rdata <= rom[imem_addr];
  always @(posedge clk) if (!rst && dmem_wvalid && dmem_wready) begin
    dmem[dmem_waddr] <= dmem_wdata;
    n_writes <= n_writes + 1;
  end

  function automatic logic [15:0] enc(int op, int rd, int rs, int imm);
    return {4'(op), 2'(rd), 2'(rs), 8'(imm)};
  endfunction

  function automatic bit m_reads(logic [15:0] i);
    return i[15:12] inside {4'd2, 4'd3, 4'd4, 4'd5};
  endfunction
  function automatic int m_src(logic [15:0] i);
    return (i[15:12] == 4'd3) ? int'(i[11:10]) : int'(i[9:8]);
  endfunction
  function automatic bit m_haz();
    return m_exv && m_reads(m_ex) && m_wbv && m_wen && (m_rd == m_src(m_ex));
  endfunction
  function automatic bit m_dstall();
    return m_wbv && m_st && !dmem_wready;
  endfunction
  function automatic bit m_go();
    return !m_halt && !(m_exv && m_ex[15:12] inside {4'd5, 4'd6}) && !m_haz() && !m_dstall();
  endfunction

  always @(posedge clk) begin
    edges <= edges + 1;
    if (rst) begin
      m_pc = 0; m_cnt = 0; m_exv = 0; m_halt = 0; m_wbv = 0;
      foreach (m_regs[k]) m_regs[k] = 0;
    end else if (!m_dstall()) begin
      bit go, hz, nv, nw, ns;
      int a, nrd, nval, naddr, op;
      go = m_go(); hz = m_haz();
      op = int'(m_ex[15:12]); a = m_regs[m_src(m_ex)];
      nv = m_exv && !hz; nw = op inside {1, 2, 3}; ns = (op == 4);
      nrd = int'(m_ex[11:10]); naddr = int'(m_ex[7:0]);
      nval = (op == 1) ? int'(m_ex[7:0]) : (op == 3) ? ((a + int'(m_ex[7:0])) % 256) : a;
      if (m_wbv) begin
        m_cnt++;
        if (m_wen) m_regs[m_rd] = m_val;
      end
      m_wbv = nv; m_wen = nw; m_st = ns; m_rd = nrd; m_val = nval; m_addr = naddr;
      if (!hz) begin
        if (m_exv && op == 5 && a == 0) m_pc = int'(m_ex[7:0]);
        if (m_exv && op == 6) m_halt = 1;
        m_exv = go;
        if (go) begin m_ex = rom[m_pc]; m_pc = (m_pc + 1) % 256; end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!rst) begin
    chk(imem_en == m_go(), "R2", "imem_en", int'(imem_en), int'(m_go()));
    chk(int'(imem_addr) == m_pc, "R4", "imem_addr", int'(imem_addr), m_pc);
    chk(dmem_wvalid == (m_wbv && m_st), "R6", "dmem_wvalid", int'(dmem_wvalid), int'(m_wbv && m_st));
    if (dmem_wvalid) begin
      chk(int'(dmem_waddr) == m_addr, "R6", "dmem_waddr", int'(dmem_waddr), m_addr);
      chk(int'(dmem_wdata) == m_val, "R1", "dmem_wdata", int'(dmem_wdata), m_val);
    end
    for (int k = 0; k < 4; k++)
      chk(int'(dbg_regs[8*k +: 8]) == m_regs[k], "R1", "dbg_regs", int'(dbg_regs[8*k +: 8]), m_regs[k]);
    chk(int'(dbg_retired) == m_cnt, "R8", "dbg_retired", int'(dbg_retired), m_cnt);
    chk(done == (m_halt && !m_wbv), "R5", "done", int'(done), int'(m_halt && !m_wbv));
  end

  always @(negedge clk) if (bp_mode) dmem_wready <= (edges % 3 == 0);

  task automatic clear_rom();
    for (int k = 0; k < 256; k++) rom[k] = 16'h0000;
    for (int k = 0; k < 256; k++) dmem[k] = 8'h00;
  endtask

  // reset, check reset state, release; returns after the release negedge
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    // R7: state after reset edges
    chk(dbg_retired == 0, "R7", "retired after reset", int'(dbg_retired), 0);
    chk(done == 0, "R7", "done after reset", int'(done), 0);
    chk(dbg_regs == 0, "R7", "regs after reset", int'(dbg_regs), 0);
    chk(imem_addr == 0, "R7", "pc after reset", int'(imem_addr), 0);
    rst = 1'b0;
    n_writes = 0;
  endtask

  // count edges after reset release until done
  task automatic run_until_done(output int n);
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R5", "watchdog: program did not finish", n, 0);
  endtask

  initial begin
    int n;
    // P1: independent loads, throughput and latency (R2)
    clear_rom();
    rom[0] = enc(1, 0, 0, 8'h05); rom[1] = enc(1, 1, 0, 8'h07);
    rom[2] = enc(1, 2, 0, 8'h09); rom[3] = enc(1, 3, 0, 8'h01);
    rom[4] = enc(6, 0, 0, 0);
    do_reset();
    repeat (5) @(negedge clk);
    chk(dbg_retired == 3, "R2", "retired after 5 edges", int'(dbg_retired), 3);
    @(negedge clk);
    chk(dbg_retired == 4, "R2", "retired after 6 edges", int'(dbg_retired), 4);
    chk(done == 0, "R5", "done before halt retires", int'(done), 0);
    @(negedge clk);
    chk(done == 1, "R5", "done after 7 edges", int'(done), 1);
    chk(dbg_regs == 32'h01090705, "R1", "load results", int'(dbg_regs), 32'h01090705);
    repeat (3) @(negedge clk);
    chk(done == 1 && dbg_retired == 5, "R5", "done sticky, retired", int'(dbg_retired), 5);

    // P2: dependence chain, one stall per dependence (R3)
    clear_rom();
    rom[0] = enc(1, 1, 0, 8'h03); rom[1] = enc(3, 1, 0, 8'h04);
    rom[2] = enc(2, 2, 1, 0);     rom[3] = enc(4, 0, 2, 8'h30);
    rom[4] = enc(6, 0, 0, 0);
    do_reset();
    repeat (9) @(negedge clk);
    chk(done == 0, "R3", "not done after 9 edges", int'(done), 0);
    @(negedge clk);
    chk(done == 1, "R3", "done after 10 edges", int'(done), 1);
    chk(dmem[8'h30] == 8'h07, "R1", "stored sum", int'(dmem[8'h30]), 7);
    chk(n_writes == 1, "R6", "one store", n_writes, 1);

    // P3: taken and not-taken branches, undefined opcode (R4, R9)
    clear_rom();
    rom[0] = enc(1, 0, 0, 0);     rom[1] = enc(5, 0, 0, 4);
    rom[2] = enc(1, 3, 0, 8'h55); rom[3] = enc(1, 3, 0, 8'h66);
    rom[4] = enc(1, 3, 0, 8'h11); rom[5] = enc(1, 1, 0, 1);
    rom[6] = enc(5, 0, 1, 2);     rom[7] = enc(1, 2, 0, 8'h22);
    rom[8] = 16'hF3AB;            rom[9] = enc(6, 0, 0, 0);
    do_reset();
    run_until_done(n);
    chk(dbg_regs[31:24] == 8'h11, "R4", "taken branch skipped", int'(dbg_regs[31:24]), 8'h11);
    chk(dbg_regs[23:16] == 8'h22, "R4", "fall-through ran", int'(dbg_regs[23:16]), 8'h22);
    chk(dbg_regs[15:0] == 16'h0100, "R9", "no-op left regs", int'(dbg_regs[15:0]), 16'h0100);
    chk(dbg_retired == 8, "R8", "retired count", int'(dbg_retired), 8);
    chk(n_writes == 0, "R9", "no store from no-op", n_writes, 0);

    // P4: stores under back-pressure (R6)
    clear_rom();
    rom[0] = enc(1, 0, 0, 8'hAB); rom[1] = enc(4, 0, 0, 8'h10);
    rom[2] = enc(1, 1, 0, 8'h01); rom[3] = enc(3, 1, 0, 8'h02);
    rom[4] = enc(4, 0, 1, 8'h11); rom[5] = enc(3, 1, 0, 8'hFF);
    rom[6] = enc(6, 0, 0, 0);
    bp_mode = 1;
    do_reset();
    run_until_done(n);
    bp_mode = 0;
    chk(n_writes == 2, "R6", "stores delivered once", n_writes, 2);
    chk(dmem[8'h10] == 8'hAB, "R6", "first store", int'(dmem[8'h10]), 8'hAB);
    chk(dmem[8'h11] == 8'h03, "R6", "second store", int'(dmem[8'h11]), 3);
    chk(dbg_regs[15:8] == 8'h02, "R1", "add wraps", int'(dbg_regs[15:8]), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", edges);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule